// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a multicycle datapath, built as a microprogram sequencer and not as a hand-coded state machine. A 4-bit micro-program counter indexes a constant microcode store. Each microword holds one bit or one field per datapath control line, and a 2-bit sequencing field sits at its low end. The control word goes straight to the datapath, so it depends only on the current micro-address.

The sequencing field picks where the next micro-address comes from. It can be address zero, the incremented micro-PC, or one of two lookup tables indexed by the 6-bit instruction opcode. One table is used after decode and the other after address calculation. The datapath holds the opcode stable in its instruction register, and the sequencer reads it combinationally when it takes a dispatch.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 and `ctrl` shows the fetch word. The reset acts asynchronously, and after release the sequence starts from micro-address 0.
- R2: Micro-addresses 0, 3 and 6 hold sequencing code 3, so the next micro-address is the current one plus one.
- R3: Micro-addresses 4, 5, 7, 8 and 9 hold sequencing code 0, so the next micro-address is 0.
- R4: Micro-address 1 dispatches through the first table on the opcode present in that cycle: 000000 gives 6, 000010 gives 9, 000100 gives 8, and 100011 or 101011 give 2.
- R5: Micro-address 2 dispatches through the second table: 100011 gives 3 and 101011 gives 5.
- R6: An opcode that is absent from the table in use gives next micro-address 0.
- R7: `ctrl` bit order, MSB first, is: [15] pc_wr, [14] pc_wr_cond, [13] addr_from_alu, [12] mem_rd, [11] mem_wr, [10] ir_wr, [9] wb_from_mem, [8:7] pc_src, [6:5] alu_op, [4:3] alu_b_sel, [2] alu_a_sel, [1] reg_wr, [0] reg_dst_rd. Its value per micro-address 0..9 is 9408, 0018, 0014, 3000, 0202, 2800, 0044, 0003, 40A4, 8100 (hex).
- R8: `upc` never exceeds 9 for any opcode sequence.
- R9: `ctrl` and `upc` do not change when `opcode` changes between clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| ctrl | output | 16 | Datapath control word for the current micro-address |
| upc | output | 4 | Current micro-program counter |

## Verification
The hardest case to reach is a dispatch miss in the second table. The opcode has to be a load or store when the first table is consulted and something else one cycle later, which a real instruction register would never present. The stimulus draws a fresh opcode every cycle, mostly from the five known values, so a load/store followed by a different opcode comes up often. Directed runs that hold each opcode steady, including unknown ones, cover the complete paths and the first-table misses.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int UPC_W     = 4;
  localparam int OP_W      = 6;
  localparam int LAST_USED = 9;

  typedef enum logic [1:0] {
    SEQ_ZERO  = 2'd0,
    SEQ_DISP1 = 2'd1,
    SEQ_DISP2 = 2'd2,
    SEQ_INCR  = 2'd3
  } seq_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_from_alu;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_from_mem;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic [1:0] alu_b_sel;
    logic       alu_a_sel;
    logic       reg_wr;
    logic       reg_dst_rd;
  } ctrl_t;

  typedef struct packed {
    ctrl_t ctrl;
    seq_e  seq;
  } uword_t;
endpackage

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  always_comb begin
    word = '0;
    word.seq = SEQ_ZERO;
    case (addr)
      AW'(0): begin // fetch
        word.ctrl.mem_rd    = 1'b1;
        word.ctrl.ir_wr     = 1'b1;
        word.ctrl.alu_b_sel = 2'b01;
        word.ctrl.pc_wr     = 1'b1;
        word.seq            = SEQ_INCR;
      end
      AW'(1): begin // decode
        word.ctrl.alu_b_sel = 2'b11;
        word.seq            = SEQ_DISP1;
      end
      AW'(2): begin // address calculation
        word.ctrl.alu_a_sel = 1'b1;
        word.ctrl.alu_b_sel = 2'b10;
        word.seq            = SEQ_DISP2;
      end
      AW'(3): begin // load read
        word.ctrl.mem_rd        = 1'b1;
        word.ctrl.addr_from_alu = 1'b1;
        word.seq                = SEQ_INCR;
      end
      AW'(4): begin // load write-back
        word.ctrl.reg_wr      = 1'b1;
        word.ctrl.wb_from_mem = 1'b1;
      end
      AW'(5): begin // store
        word.ctrl.mem_wr        = 1'b1;
        word.ctrl.addr_from_alu = 1'b1;
      end
      AW'(6): begin // register op execute
        word.ctrl.alu_a_sel = 1'b1;
        word.ctrl.alu_op    = 2'b10;
        word.seq            = SEQ_INCR;
      end
      AW'(7): begin // register op write-back
        word.ctrl.reg_wr     = 1'b1;
        word.ctrl.reg_dst_rd = 1'b1;
      end
      AW'(8): begin // branch
        word.ctrl.alu_a_sel  = 1'b1;
        word.ctrl.alu_op     = 2'b01;
        word.ctrl.pc_wr_cond = 1'b1;
        word.ctrl.pc_src     = 2'b01;
      end
      AW'(9): begin // jump
        word.ctrl.pc_wr  = 1'b1;
        word.ctrl.pc_src = 2'b10;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/useq_dispatch.sv
`timescale 1ns/1ps
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int AW    = UPC_W,
  parameter int OW    = OP_W,
  parameter int TABLE = 1
) (
  input  logic [OW-1:0] op,
  output logic [AW-1:0] target
);
  generate
    if (TABLE == 1) begin : g_decode_tbl
      always_comb begin
        case (op)
          OW'(6'b000000): target = AW'(6);
          OW'(6'b000010): target = AW'(9);
          OW'(6'b000100): target = AW'(8);
          OW'(6'b100011): target = AW'(2);
          OW'(6'b101011): target = AW'(2);
          default:        target = '0;
        endcase
      end
    end else begin : g_mem_tbl
      always_comb begin
        case (op)
          OW'(6'b100011): target = AW'(3);
          OW'(6'b101011): target = AW'(5);
          default:        target = '0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/useq_next.sv
`timescale 1ns/1ps
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_e          seq,
  input  logic [AW-1:0] disp1,
  input  logic [AW-1:0] disp2,
  output logic [AW-1:0] upc_q
);
  logic [AW-1:0] upc_d;
  logic          upc_en;

  always_comb begin
    upc_en = 1'b1;
    unique case (seq)
      SEQ_ZERO:  upc_d = '0;
      SEQ_DISP1: upc_d = disp1;
      SEQ_DISP2: upc_d = disp2;
      SEQ_INCR:  upc_d = upc_q + AW'(1);
      default:   upc_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upc_q <= '0;
    else if (upc_en) upc_q <= upc_d;
  end

  // R3
  ret_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SEQ_ZERO) |=> (upc_q == '0));
  // R2
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SEQ_INCR) |=> (upc_q == $past(upc_q) + AW'(1)));
  // R8
  upc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upc_q <= AW'(LAST_USED));
endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  opcode,
  output logic [15:0]      ctrl,
  output logic [UPC_W-1:0] upc
);
  uword_t           word;
  logic [UPC_W-1:0] disp1;
  logic [UPC_W-1:0] disp2;
  logic [UPC_W-1:0] upc_q;

  useq_rom #(.AW(UPC_W)) u_rom (.addr(upc_q), .word(word));

  useq_dispatch #(.AW(UPC_W), .OW(OP_W), .TABLE(1)) u_disp1 (
    .op(opcode), .target(disp1));
  useq_dispatch #(.AW(UPC_W), .OW(OP_W), .TABLE(2)) u_disp2 (
    .op(opcode), .target(disp2));

  useq_next #(.AW(UPC_W)) u_next (
    .clk(clk), .rst_n(rst_n), .seq(word.seq),
    .disp1(disp1), .disp2(disp2), .upc_q(upc_q));

  assign ctrl = word.ctrl;
  assign upc  = upc_q;

  // R4
  beq_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd1 && opcode == 6'b000100) |=> (upc == 4'd8));
  // R5
  store_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd2 && opcode == 6'b101011) |=> (upc == 4'd5));
  // R6
  disp2_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd2 && opcode != 6'b100011 && opcode != 6'b101011) |=> (upc == 4'd0));
endmodule

// File: tb/sim_useq_ctrl.sv
`timescale 1ns/1ps
module sim_useq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  opcode;
  logic [15:0] ctrl;
  logic [3:0]  upc;

  int checks = 0;
  int errors = 0;
  bit fix_en = 1'b0;
  logic [5:0] fix_val = '0;
  logic [3:0] exp_upc;
  string      exp_tag;

  always #2.5 clk = ~clk;

  useq_ctrl u0 (.clk(clk), .rst_n(rst_n), .opcode(opcode), .ctrl(ctrl), .upc(upc));

  function automatic logic [15:0] exp_ctrl(input logic [3:0] a);
    case (a)
      4'd0: return 16'h9408;
      4'd1: return 16'h0018;
      4'd2: return 16'h0014;
      4'd3: return 16'h3000;
      4'd4: return 16'h0202;
      4'd5: return 16'h2800;
      4'd6: return 16'h0044;
      4'd7: return 16'h0003;
      4'd8: return 16'h40A4;
      4'd9: return 16'h8100;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [3:0] tbl1(input logic [5:0] o);
    case (o)
      6'b000000: return 4'd6;
      6'b000010: return 4'd9;
      6'b000100: return 4'd8;
      6'b100011, 6'b101011: return 4'd2;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] tbl2(input logic [5:0] o);
    case (o)
      6'b100011: return 4'd3;
      6'b101011: return 4'd5;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] exp_next(input logic [3:0] a, input logic [5:0] o);
    case (a)
      4'd0, 4'd3, 4'd6: return a + 4'd1;
      4'd1: return tbl1(o);
      4'd2: return tbl2(o);
      default: return 4'd0;
    endcase
  endfunction

  function automatic string next_tag(input logic [3:0] a, input logic [5:0] o);
    case (a)
      4'd0, 4'd3, 4'd6: return "R2";
      4'd1: return (tbl1(o) == 4'd0) ? "R6" : "R4";
      4'd2: return (tbl2(o) == 4'd0) ? "R6" : "R5";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [5:0] pick();
    logic [5:0] known [5] = '{6'b000000, 6'b000010, 6'b000100, 6'b100011, 6'b101011};
    if (fix_en) return fix_val;
    if (($urandom % 4) != 0) return known[$urandom % 5];
    return 6'($urandom);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(upc == exp_upc, exp_tag, 16'(upc), 16'(exp_upc));
    chk(ctrl == exp_ctrl(exp_upc), "R7", ctrl, exp_ctrl(exp_upc));
    chk(upc <= 4'd9, "R8", 16'(upc), 16'd9);
    opcode = pick();
    #1;
    // R9: an opcode change between edges leaves outputs alone
    chk(ctrl == exp_ctrl(exp_upc), "R9", ctrl, exp_ctrl(exp_upc));
    chk(upc == exp_upc, "R9", 16'(upc), 16'(exp_upc));
    opcode = pick();
    exp_tag = next_tag(exp_upc, opcode);
    exp_upc = exp_next(exp_upc, opcode);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] dir [7] = '{6'b000000, 6'b000010, 6'b000100, 6'b100011,
                            6'b101011, 6'b111111, 6'b000001};
    void'($urandom(32'd20240611));
    rst_n  = 1'b0;
    opcode = 6'b100011;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(upc == 4'd0, "R1", 16'(upc), 16'd0);
    chk(ctrl == 16'h9408, "R1", ctrl, 16'h9408);
    rst_n   = 1'b1;
    exp_upc = 4'd0;
    opcode  = pick();
    exp_tag = next_tag(exp_upc, opcode);
    exp_upc = exp_next(exp_upc, opcode);

    // directed: each opcode held for whole instructions (R4, R5, R6 corners)
    fix_en = 1'b1;
    foreach (dir[i]) begin
      fix_val = dir[i];
      repeat (14) step();
    end
    fix_en = 1'b0;

    // random per-cycle opcodes
    repeat (2500) step();

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk(upc == 4'd0, "R1", 16'(upc), 16'd0);
    chk(ctrl == 16'h9408, "R1", ctrl, 16'h9408);
    @(negedge clk);
    rst_n   = 1'b1;
    exp_upc = 4'd0;
    opcode  = pick();
    exp_tag = next_tag(exp_upc, opcode);
    exp_upc = exp_next(exp_upc, opcode);
    repeat (200) step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule